// File: doc/BRIEF.md
# Sound Processor Port and Memory Decoder

This block sits beside the sound processor and turns its I/O port and memory accesses into chip strobes and data paths. The port space is decoded on its low five address bits only, so the same 32-port map repeats across all 256 ports. The bottom of that map holds five sound-generator chips, with four ports per chip. Each chip gets a register-select strobe, a register-read strobe and a register-write strobe. Register reads return that chip's data bus.

Two more port groups serve a drum coprocessor. A write to the command group stores a command byte. The command values 0x00 to 0x07 have meaning, and 0x00 silences everything. Software writes the command first. It then touches the interrupt group, and any access there raises an interrupt to the coprocessor, whatever the data. The interrupt stays raised until the coprocessor acknowledges it.

On the memory side there are two regions. A read anywhere in 0x8000–0x9FFF returns the byte that the main CPU last loaded into its command latch. A 512-byte RAM answers throughout 0x6000–0x7FFF, with the address wrapping every 512 bytes.

Top module: `snd_port_decode`

## Requirements
- R1: Port address bits 7:5 are ignored: ports p and p+0x20·n behave identically for every strobe and read value.
- R2: A port write (io_wr) to port 4k+0 with k in 0..4 pulses psg_sel[k] in the same cycle. No other chip strobe is active.
- R3: A port read (io_rd) from port 4k+1 pulses psg_rd[k] in the same cycle. io_rdata then carries psg_rdata[8k+7:8k].
- R4: A port write to port 4k+2 pulses psg_wr[k] in the same cycle.
- R5: The following produce no chip strobe: offset 3 of a chip group, a read at offset 0 or 2, a write at offset 1, and ports 0x14–0x1F. Every port read other than a register read returns 0xFF, and io_rdata is 0xFF when io_rd is low.
- R6: A port write to 0x18–0x1B loads io_wdata into drum_cmd at the next clock edge. drum_cmd changes at no other time.
- R7: Any read or write of ports 0x14–0x17 sets drum_irq at the next clock edge, whatever the data. drum_cmd is left unchanged.
- R8: drum_irq stays high until drum_ack is seen, and clears at the edge after the ack. A new interrupt access takes priority over an ack in the same cycle.
- R9: host_ld loads host_data into the main-CPU latch at the clock edge. A memory read in 0x8000–0x9FFF returns that latch in the same cycle. host_data has no effect without host_ld.
- R10: A memory write in 0x6000–0x7FFF stores into a 512-byte RAM indexed by address bits 8:0. A read in the same range returns the stored byte in the same cycle.
- R11: Memory reads outside 0x6000–0x9FFF return 0xFF, as does mem_rdata when mem_rd is low. Memory writes outside 0x6000–0x7FFF change no RAM byte.
- R12: After reset, drum_cmd is 0x00, drum_irq is low, the main-CPU latch reads 0x00, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | Port address |
| io_rd | input | 1 | Port read cycle |
| io_wr | input | 1 | Port write cycle |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read data |
| psg_sel | output | 5 | Register-select strobe per sound chip |
| psg_rd | output | 5 | Register-read strobe per sound chip |
| psg_wr | output | 5 | Register-write strobe per sound chip |
| psg_rdata | input | 40 | Read data from the chips, 8 bits each, chip 0 lowest |
| drum_cmd | output | 8 | Latched drum command byte |
| drum_irq | output | 1 | Interrupt to the drum coprocessor |
| drum_ack | input | 1 | Interrupt acknowledge from the coprocessor |
| mem_addr | input | 16 | Memory address |
| mem_rd | input | 1 | Memory read cycle |
| mem_wr | input | 1 | Memory write cycle |
| mem_wdata | input | 8 | Memory write data |
| mem_rdata | output | 8 | Memory read data |
| host_ld | input | 1 | Main CPU loads its command latch |
| host_data | input | 8 | Main CPU command byte |

## Verification
The assertions assume that io_rd and io_wr are never high in the same cycle, since the processor runs one port cycle at a time. They also assume that host_ld is held low during reset, because the latch-read property looks one cycle back at it. The stimulus applies one access per cycle and drops every strobe on idle cycles. It covers each chip at all four offsets, using a different upper address alias for each chip, and also reaches the drum groups through aliased addresses. The ack is placed both alone and in the same cycle as a new interrupt access.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;
  localparam int NUM_PSG   = 5;   // sound chips, four ports each
  localparam int PORT_BITS = 5;   // decoded port bits, the rest alias
  localparam int GRP_BITS  = PORT_BITS - 2;
  localparam int MEM_AW    = 16;
  localparam int RAM_AW    = 9;   // 512 bytes
  localparam int DW        = 8;

  // memory regions keyed on the top three address bits
  localparam logic [2:0] RAM_TAG   = 3'b011;  // 0x6000-0x7FFF
  localparam logic [2:0] LATCH_TAG = 3'b100;  // 0x8000-0x9FFF

  // port groups following the sound chips
  localparam logic [GRP_BITS-1:0] IRQ_GRP = GRP_BITS'(NUM_PSG);
  localparam logic [GRP_BITS-1:0] CMD_GRP = GRP_BITS'(NUM_PSG + 1);

  localparam logic [DW-1:0] IDLE_BYTE = '1;
endpackage

// File: rtl/snd_port_sel.sv
module snd_port_sel
  import snd_dec_pkg::*;
(
  input  logic [PORT_BITS-1:0] port,
  input  logic                 rd,
  input  logic                 wr,
  output logic [NUM_PSG-1:0]   sel_o,
  output logic [NUM_PSG-1:0]   rd_o,
  output logic [NUM_PSG-1:0]   wr_o,
  output logic                 irq_hit,
  output logic                 cmd_hit
);
  logic [GRP_BITS-1:0] grp;
  logic [1:0]          off;

  assign grp = port[PORT_BITS-1:2];
  assign off = port[1:0];

  for (genvar k = 0; k < NUM_PSG; k++) begin : g_chip
    logic mine;
    assign mine     = (grp == GRP_BITS'(k));
    assign sel_o[k] = mine && wr && (off == 2'd0);
    assign rd_o[k]  = mine && rd && (off == 2'd1);
    assign wr_o[k]  = mine && wr && (off == 2'd2);
  end

  assign irq_hit = (rd || wr) && (grp == IRQ_GRP);
  assign cmd_hit = wr && (grp == CMD_GRP);
endmodule

// File: rtl/snd_drum_ctl.sv
module snd_drum_ctl
  import snd_dec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [DW-1:0] cmd_in,
  input  logic          irq_set,
  input  logic          irq_ack,
  output logic [DW-1:0] cmd_q,
  output logic          irq_q
);
  logic [DW-1:0] cmd_nxt;
  logic          irq_nxt;

  always_comb begin
    cmd_nxt = cmd_q;
    if (cmd_we) cmd_nxt = cmd_in;
    irq_nxt = irq_q;
    if (irq_set)      irq_nxt = 1'b1;
    else if (irq_ack) irq_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cmd_q <= cmd_nxt;
      irq_q <= irq_nxt;
    end
  end
endmodule

// File: rtl/snd_mem_map.sv
module snd_mem_map
  import snd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic              host_ld,
  input  logic [DW-1:0]     host_data,
  output logic [DW-1:0]     rdata
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [DW-1:0]     ram [RAM_DEPTH];
  logic [DW-1:0]     latch_q;
  logic [DW-1:0]     latch_nxt;
  logic [2:0]        tag;
  logic [RAM_AW-1:0] idx;
  logic              ram_we;
  logic              unused_addr;

  assign tag         = addr[MEM_AW-1:MEM_AW-3];
  assign idx         = addr[RAM_AW-1:0];
  assign ram_we      = wr && (tag == RAM_TAG);
  assign unused_addr = ^addr[MEM_AW-4:RAM_AW];

  always_comb begin
    latch_nxt = latch_q;
    if (host_ld) latch_nxt = host_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_nxt;
  end

  always_ff @(posedge clk) begin
    if (ram_we) ram[idx] <= wdata;
  end

  always_comb begin
    rdata = IDLE_BYTE;
    if (rd) begin
      if (tag == RAM_TAG)        rdata = ram[idx];
      else if (tag == LATCH_TAG) rdata = latch_q;
    end
  end
endmodule

// File: rtl/snd_port_decode.sv
module snd_port_decode
  import snd_dec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            io_addr,
  input  logic                  io_rd,
  input  logic                  io_wr,
  input  logic [DW-1:0]         io_wdata,
  output logic [DW-1:0]         io_rdata,
  output logic [NUM_PSG-1:0]    psg_sel,
  output logic [NUM_PSG-1:0]    psg_rd,
  output logic [NUM_PSG-1:0]    psg_wr,
  input  logic [NUM_PSG*DW-1:0] psg_rdata,
  output logic [DW-1:0]         drum_cmd,
  output logic                  drum_irq,
  input  logic                  drum_ack,
  input  logic [MEM_AW-1:0]     mem_addr,
  input  logic                  mem_rd,
  input  logic                  mem_wr,
  input  logic [DW-1:0]         mem_wdata,
  output logic [DW-1:0]         mem_rdata,
  input  logic                  host_ld,
  input  logic [DW-1:0]         host_data
);
  logic irq_hit;
  logic cmd_hit;
  logic unused_alias;

  assign unused_alias = ^io_addr[7:PORT_BITS];

  snd_port_sel u_sel (
    .port    (io_addr[PORT_BITS-1:0]),
    .rd      (io_rd),
    .wr      (io_wr),
    .sel_o   (psg_sel),
    .rd_o    (psg_rd),
    .wr_o    (psg_wr),
    .irq_hit (irq_hit),
    .cmd_hit (cmd_hit)
  );

  snd_drum_ctl u_drum (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_we  (cmd_hit),
    .cmd_in  (io_wdata),
    .irq_set (irq_hit),
    .irq_ack (drum_ack),
    .cmd_q   (drum_cmd),
    .irq_q   (drum_irq)
  );

  snd_mem_map u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (mem_addr),
    .rd        (mem_rd),
    .wr        (mem_wr),
    .wdata     (mem_wdata),
    .host_ld   (host_ld),
    .host_data (host_data),
    .rdata     (mem_rdata)
  );

  // read strobes are one-hot, so an OR of gated chip buses suffices
  always_comb begin
    logic [DW-1:0] acc;
    acc = '0;
    for (int k = 0; k < NUM_PSG; k++)
      if (psg_rd[k]) acc = acc | psg_rdata[k*DW +: DW];
    io_rdata = (|psg_rd) ? acc : IDLE_BYTE;
  end
endmodule

// File: rtl/snd_port_decode_chk.sv
module snd_port_decode_chk
  import snd_dec_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [7:0]            io_addr,
  input logic                  io_rd,
  input logic                  io_wr,
  input logic [DW-1:0]         io_wdata,
  input logic [DW-1:0]         io_rdata,
  input logic [NUM_PSG-1:0]    psg_sel,
  input logic [NUM_PSG-1:0]    psg_rd,
  input logic [NUM_PSG-1:0]    psg_wr,
  input logic [DW-1:0]         drum_cmd,
  input logic                  drum_irq,
  input logic                  drum_ack,
  input logic [MEM_AW-1:0]     mem_addr,
  input logic                  mem_rd,
  input logic [DW-1:0]         mem_rdata,
  input logic                  host_ld,
  input logic [DW-1:0]         host_data
);
  logic unused_bits;
  assign unused_bits = ^{io_addr[7:5], mem_addr[12:0]};

  // R2: at most one chip strobe of any kind per cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({psg_sel, psg_rd, psg_wr}));

  // R5: offset 3 of a chip group reads as idle
  p_off3_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr[1:0] == 2'd3) |-> (io_rdata == 8'hFF && psg_rd == '0));

  // R6: command byte loads from the write data
  p_cmd_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr[4:2] == 3'b110) |=> (drum_cmd == $past(io_wdata)));

  // R6: command byte otherwise holds
  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr[4:2] == 3'b110) |=> $stable(drum_cmd));

  // R7: interrupt-group access raises the interrupt
  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && io_addr[4:2] == 3'b101) |=> drum_irq);

  // R8: interrupt persists until acknowledged
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drum_irq && !drum_ack) |=> drum_irq);

  // R8: interrupt only rises after an interrupt-group access
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drum_irq) |-> $past((io_rd || io_wr) && io_addr[4:2] == 3'b101));

  // R9: latch region returns the byte just loaded by the main CPU
  p_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr[15:13] == 3'b100 && $past(host_ld))
      |-> (mem_rdata == $past(host_data)));
endmodule

bind snd_port_decode snd_port_decode_chk i_chk (.*);

// File: tb/test_snd_port_decode.sv
module test_snd_port_decode;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  io_addr, io_wdata, io_rdata;
  logic        io_rd, io_wr;
  logic [4:0]  psg_sel, psg_rd, psg_wr;
  logic [39:0] psg_rdata;
  logic [7:0]  drum_cmd;
  logic        drum_irq, drum_ack;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        host_ld;
  logic [7:0]  host_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  snd_port_decode i_snd_port_decode (.*);

  // chip k returns 0xA0+k
  for (genvar k = 0; k < 5; k++) begin : g_rd
    assign psg_rdata[k*8 +: 8] = 8'hA0 + 8'(k);
  end

  typedef enum int {K_STB, K_IORD, K_MEMRD, K_CMD, K_IRQ} kind_t;
  typedef struct {kind_t kind; logic [15:0] exp; string req;} item_t;
  item_t q[$];

  task automatic expect_val(kind_t kd, logic [15:0] e, string r);
    item_t it;
    it.kind = kd; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        K_STB:   act = {1'b0, psg_sel, psg_rd, psg_wr};
        K_IORD:  act = {8'h00, io_rdata};
        K_MEMRD: act = {8'h00, mem_rdata};
        K_CMD:   act = {8'h00, drum_cmd};
        default: act = {15'h0, drum_irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  function automatic logic [15:0] model_stb(logic rd, logic wr, logic [7:0] a);
    logic [15:0] s;
    int g;
    int o;
    s = '0; g = int'(a[4:2]); o = int'(a[1:0]);
    if (g < 5) begin
      if (wr && o == 0) s[10+g] = 1'b1;
      if (rd && o == 1) s[5+g]  = 1'b1;
      if (wr && o == 2) s[g]    = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [15:0] model_rd(logic rd, logic [7:0] a);
    if (rd && a[4:2] < 3'd5 && a[1:0] == 2'd1) return {8'h00, 8'hA0 + 8'(a[4:2])};
    return 16'h00FF;
  endfunction

  task automatic idle();
    @(posedge clk); #1;
    io_rd = 0; io_wr = 0; mem_rd = 0; mem_wr = 0; host_ld = 0; drum_ack = 0;
  endtask

  task automatic port(logic rd, logic wr, logic [7:0] a, logic [7:0] d, string r);
    @(posedge clk); #1;
    io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
    mem_rd = 0; mem_wr = 0; host_ld = 0; drum_ack = 0;
    expect_val(K_STB, model_stb(rd, wr, a), r);
    expect_val(K_IORD, model_rd(rd, a), r);
  endtask

  task automatic mem(logic rd, logic wr, logic [15:0] a, logic [7:0] d);
    @(posedge clk); #1;
    io_rd = 0; io_wr = 0; mem_rd = rd; mem_wr = wr; mem_addr = a; mem_wdata = d;
    host_ld = 0; drum_ack = 0;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; io_rd = 0; io_wr = 0; io_addr = 0; io_wdata = 0; drum_ack = 0;
    mem_rd = 0; mem_wr = 0; mem_addr = 0; mem_wdata = 0; host_ld = 0; host_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R12: reset state
    idle();
    expect_val(K_CMD, 16'h0000, "R12");
    expect_val(K_IRQ, 16'h0000, "R12");
    expect_val(K_STB, 16'h0000, "R12");
    expect_val(K_IORD, 16'h00FF, "R5");
    mem(1, 0, 16'h8000, 8'h00);
    expect_val(K_MEMRD, 16'h0000, "R12");

    // R1..R5: each chip at each offset, read and write, with aliasing
    for (int k = 0; k < 5; k++) begin
      for (int o = 0; o < 4; o++) begin
        logic [7:0] a;
        a = 8'((((k * 3) % 8) << 5) | (k * 4) | o);
        port(0, 1, a, 8'h5A, "R2 R4 R5 R1");
        port(1, 0, a, 8'h00, "R3 R5 R1");
      end
    end
    // R5: drum groups and unused group produce no strobe and read idle
    port(1, 0, 8'h1D, 8'h00, "R5");
    port(1, 0, 8'h18, 8'h00, "R5");
    idle();

    // R6: command load, including an aliased port
    port(0, 1, 8'h19, 8'h05, "R6");
    idle();
    expect_val(K_CMD, 16'h0005, "R6");
    expect_val(K_IRQ, 16'h0000, "R6");
    port(0, 1, 8'h3A, 8'h03, "R6 R1");
    idle();
    expect_val(K_CMD, 16'h0003, "R6");
    port(1, 0, 8'h1B, 8'h00, "R6");
    port(0, 1, 8'h0A, 8'h77, "R6");
    idle();
    expect_val(K_CMD, 16'h0003, "R6");

    // R7: any access to interrupt group, data ignored
    port(1, 0, 8'hF5, 8'h00, "R7");
    idle();
    expect_val(K_IRQ, 16'h0001, "R7");
    expect_val(K_CMD, 16'h0003, "R7");

    // R8: held until ack
    idle(); idle(); idle();
    expect_val(K_IRQ, 16'h0001, "R8");
    @(posedge clk); #1 drum_ack = 1;
    idle();
    expect_val(K_IRQ, 16'h0000, "R8");
    // R8: set wins over ack in the same cycle
    port(0, 1, 8'h16, 8'hEE, "R7");
    drum_ack = 1;
    idle();
    expect_val(K_IRQ, 16'h0001, "R8");
    expect_val(K_CMD, 16'h0003, "R7");
    @(posedge clk); #1 drum_ack = 1;
    idle();
    expect_val(K_IRQ, 16'h0000, "R8");

    // R9: main-CPU latch
    @(posedge clk); #1 host_ld = 1; host_data = 8'h42;
    mem(1, 0, 16'h9FFF, 8'h00);
    expect_val(K_MEMRD, 16'h0042, "R9");
    host_data = 8'h99;
    mem(1, 0, 16'h8000, 8'h00);
    expect_val(K_MEMRD, 16'h0042, "R9");

    // R10: RAM with aliasing
    mem(0, 1, 16'h6005, 8'h11);
    mem(1, 0, 16'h7E05, 8'h00);
    expect_val(K_MEMRD, 16'h0011, "R10");
    mem(0, 1, 16'h61FF, 8'h22);
    mem(1, 0, 16'h63FF, 8'h00);
    expect_val(K_MEMRD, 16'h0022, "R10");

    // R11: unmapped writes and reads
    mem(0, 1, 16'hA005, 8'h99);
    mem(0, 1, 16'h8005, 8'h98);
    mem(1, 0, 16'h6005, 8'h00);
    expect_val(K_MEMRD, 16'h0011, "R11");
    mem(1, 0, 16'hA005, 8'h00);
    expect_val(K_MEMRD, 16'h00FF, "R11");
    mem(1, 0, 16'h5000, 8'h00);
    expect_val(K_MEMRD, 16'h00FF, "R11");
    mem(0, 0, 16'h6005, 8'h00);
    expect_val(K_MEMRD, 16'h00FF, "R11");

    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule